// File: doc/BRIEF.md
# Vertical Sync Window Countdown

This block times the vertical deflection of a raster display from a half-line clock enable. It keeps a count of half-lines since the last frame start. A digitised frame-sync pulse restarts that count only when it falls inside an acceptance window. The window opens at line 248. It closes at line 314 while no video is identified, and at line 352 once video is identified. Counting half-lines lets both fields of an interlaced picture be placed to half a line.

Each frame start launches the vertical drive pulse and a line-PLL inhibit. It also restarts the line-count bus used for service timing. When no sync lands inside the window, the block makes its own frame start at the window end and keeps going. A separate flag selects the short line-PLL time constant. The flag turns on three lines before the nominal frame pulse at half-line 625, and stays on for the first ten lines of the new frame.

Top module: `vsw_countdown`

## Requirements
- R1: A `fsync` high in a cycle where the internal half-line count is 496 (line 248) or more, and below the window end, is accepted. It restarts the count at 0, and `line_cnt` reads 0 after that clock edge.
- R2: With no accepted sync, the block starts a frame by itself. This happens on the `half_tick` that would bring the count to the window end: 628 half-lines when `vid_ok`=0, 704 when `vid_ok`=1. The count is then 627 or 703 half-lines before that edge.
- R3: `vdrive` rises on the clock edge of a frame start. It falls on the edge of the 21st `half_tick` after that start, which makes the pulse 10.5 lines long.
- R4: A `fsync` that arrives while the count is below 496 has no effect. No `vdrive` starts and `line_cnt` keeps counting.
- R5: `line_cnt` equals the number of `half_tick` edges since the last frame start, divided by two and rounded down. It changes only on a tick or a frame start.
- R6: `pll_fast` is 1 while the half-line count is below 20 (the first ten lines of a frame) or at least 619 (three lines before 625). It is 0 otherwise.
- R7: `pll_inhibit` has the same start and the same 21-tick length as `vdrive`.
- R8: After reset, `line_cnt`=0, `vdrive`=0, `pll_inhibit`=0 and `pll_fast`=1.
- R9: When `fsync` and `half_tick` are high in the same cycle inside the window, the sync wins. The count restarts at 0 and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| half_tick | input | 1 | One-cycle enable, one per half line |
| fsync | input | 1 | Digitised frame-sync pulse |
| vid_ok | input | 1 | Video identified; selects the longer window |
| vdrive | output | 1 | Vertical drive pulse |
| pll_fast | output | 1 | Short time constant select for the line PLL |
| pll_inhibit | output | 1 | Line PLL inhibit |
| line_cnt | output | 9 | Lines since frame start |

## Verification
Frames are driven with a sync at a mid-window position, with a sync at exactly half-line 496, and with no sync under each `vid_ok` value. The mid-window case separates acceptance from free-running. The 496 case pins the lower edge of the window. The two no-sync cases show that the window end follows `vid_ok`. Further frames carry a sync at 495 and a sync at 100, which must be ignored, and a sync at 650 with video identified, which falls beyond the short window but must be accepted. Two frames put the sync on the same cycle as a tick, one of them on the very tick that would otherwise free-run, to show that the sync takes priority. On every tick the line count, the time-constant flag and the inhibit are compared against the half-line position, and each drive pulse is measured in ticks.

// File: rtl/vsw_pkg.sv
package vsw_pkg;
  typedef enum logic [1:0] {
    START_NONE = 2'd0,
    START_SYNC = 2'd1,
    START_FREE = 2'd2
  } start_cause_e;
endpackage

// File: rtl/vsw_halfline_ctr.sv
module vsw_halfline_ctr
  import vsw_pkg::*;
#(
  parameter int HCW      = 10,
  parameter int LO_HL    = 496,
  parameter int END_S_HL = 628,
  parameter int END_L_HL = 704
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           fsync,
  input  logic           vid_ok,
  output logic [HCW-1:0] hcnt,
  output logic [HCW-1:0] hcnt_next,
  output start_cause_e   cause
);
  localparam logic [HCW:0] LO_W  = (HCW+1)'(LO_HL);
  localparam logic [HCW:0] ES_W  = (HCW+1)'(END_S_HL);
  localparam logic [HCW:0] EL_W  = (HCW+1)'(END_L_HL);

  logic [HCW:0] end_hl;
  logic [HCW:0] cur_w;
  logic         in_win;
  logic         accept;
  logic         wrap;

  always_comb begin
    end_hl = vid_ok ? EL_W : ES_W;
    cur_w  = {1'b0, hcnt};
    in_win = (cur_w >= LO_W) && (cur_w < end_hl);
    accept = fsync && in_win;
    wrap   = (cur_w >= end_hl) || (tick && ((cur_w + 1'b1) >= end_hl));
    if (accept)    cause = START_SYNC;
    else if (wrap) cause = START_FREE;
    else           cause = START_NONE;
    if (cause != START_NONE) hcnt_next = '0;
    else if (tick)           hcnt_next = hcnt + 1'b1;
    else                     hcnt_next = hcnt;
  end

  always_ff @(posedge clk) begin
    if (rst) hcnt <= '0;
    else     hcnt <= hcnt_next;
  end

  AST_START_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (cause != START_NONE) |-> ({1'b0, hcnt} >= LO_W)); // R1

  AST_HCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, hcnt} <= EL_W)); // R2

  AST_EARLY_SYNC_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (fsync && ({1'b0, hcnt} < LO_W) && (hcnt != '0)) |=> (hcnt != '0)); // R4
endmodule

// File: rtl/vsw_span_timer.sv
module vsw_span_timer #(
  parameter int DUR = 21
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic tick,
  output logic active_o
);
  localparam int CW = $clog2(DUR + 1);
  localparam logic [CW-1:0] DUR_W = CW'(DUR);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_next;

  always_comb begin
    if (start)                 cnt_next = DUR_W;
    else if (tick && cnt != 0) cnt_next = cnt - 1'b1;
    else                       cnt_next = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      active_o <= 1'b0;
    end else begin
      cnt      <= cnt_next;
      active_o <= (cnt_next != '0);
    end
  end

  AST_SPAN_START: assert property (@(posedge clk) disable iff (rst)
    start |=> active_o); // R3

  AST_SPAN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!start && !tick) |=> $stable(active_o)); // R3
endmodule

// File: rtl/vsw_tc_sched.sv
module vsw_tc_sched #(
  parameter int HCW     = 10,
  parameter int PRE_HL  = 619,
  parameter int POST_HL = 20
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [HCW-1:0] hcnt_next,
  output logic           fast_o
);
  localparam logic [HCW-1:0] PRE_W  = HCW'(PRE_HL);
  localparam logic [HCW-1:0] POST_W = HCW'(POST_HL);

  always_ff @(posedge clk) begin
    if (rst) fast_o <= 1'b1;
    else     fast_o <= (hcnt_next < POST_W) || (hcnt_next >= PRE_W);
  end

  AST_FAST_AT_START: assert property (@(posedge clk) disable iff (rst)
    (hcnt_next == '0) |=> fast_o); // R6
endmodule

// File: rtl/vsw_countdown.sv
module vsw_countdown
  import vsw_pkg::*;
#(
  parameter int WIN_LO_LINE    = 248,
  parameter int WIN_HI_LINE    = 314,
  parameter int WIN_HI_ID_LINE = 352,
  parameter int VDRIVE_HALVES  = 21,
  parameter int INHIBIT_HALVES = 21,
  parameter int NOMINAL_HALVES = 625,
  parameter int PRE_LINES      = 3,
  parameter int POST_LINES     = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic half_tick,
  input  logic fsync,
  input  logic vid_ok,
  output logic vdrive,
  output logic pll_fast,
  output logic pll_inhibit,
  output logic [$clog2(2*WIN_HI_ID_LINE+1)-2:0] line_cnt
);
  localparam int HCW      = $clog2(2*WIN_HI_ID_LINE + 1);
  localparam int LO_HL    = 2*WIN_LO_LINE;
  localparam int END_S_HL = 2*WIN_HI_LINE;
  localparam int END_L_HL = 2*WIN_HI_ID_LINE;
  localparam int PRE_HL   = NOMINAL_HALVES - 2*PRE_LINES;
  localparam int POST_HL  = 2*POST_LINES;
  localparam int NSPAN    = 2;

  logic [HCW-1:0] hcnt;
  logic [HCW-1:0] hcnt_next;
  start_cause_e   cause;
  logic           frame_start;
  logic [NSPAN-1:0] span;

  vsw_halfline_ctr #(
    .HCW(HCW), .LO_HL(LO_HL), .END_S_HL(END_S_HL), .END_L_HL(END_L_HL)
  ) u_ctr (
    .clk(clk), .rst(rst), .tick(half_tick), .fsync(fsync), .vid_ok(vid_ok),
    .hcnt(hcnt), .hcnt_next(hcnt_next), .cause(cause)
  );

  assign frame_start = (cause != START_NONE);

  for (genvar gi = 0; gi < NSPAN; gi++) begin : g_span
    localparam int DUR = (gi == 0) ? VDRIVE_HALVES : INHIBIT_HALVES;
    vsw_span_timer #(.DUR(DUR)) u_span (
      .clk(clk), .rst(rst), .start(frame_start), .tick(half_tick),
      .active_o(span[gi])
    );
  end

  assign vdrive      = span[0];
  assign pll_inhibit = span[1];

  vsw_tc_sched #(.HCW(HCW), .PRE_HL(PRE_HL), .POST_HL(POST_HL)) u_tc (
    .clk(clk), .rst(rst), .hcnt_next(hcnt_next), .fast_o(pll_fast)
  );

  always_ff @(posedge clk) begin
    if (rst) line_cnt <= '0;
    else     line_cnt <= hcnt_next[HCW-1:1];
  end

  if (INHIBIT_HALVES == VDRIVE_HALVES) begin : g_chk_inh
    AST_INHIBIT_TRACKS: assert property (@(posedge clk) disable iff (rst)
      (pll_inhibit == vdrive)); // R7
  end

  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!half_tick && !frame_start) |=> $stable(line_cnt)); // R5

  AST_LINE_RESTART: assert property (@(posedge clk) disable iff (rst)
    (cause == START_SYNC) |=> (line_cnt == '0)); // R1
endmodule

// File: tb/vsw_countdown_test.sv
module vsw_countdown_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic half_tick = 1'b0;
  logic fsync = 1'b0;
  logic vid_ok = 1'b0;
  logic vdrive, pll_fast, pll_inhibit;
  logic [8:0] line_cnt;

  int checks = 0;
  int failures = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  vsw_countdown uut (
    .clk(clk), .rst(rst), .half_tick(half_tick), .fsync(fsync), .vid_ok(vid_ok),
    .vdrive(vdrive), .pll_fast(pll_fast), .pll_inhibit(pll_inhibit),
    .line_cnt(line_cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit t, input bit f);
    @(negedge clk);
    half_tick = t;
    fsync     = f;
  endtask

  // Driver: one frame. acc_h < 0 means no accepted sync (free-run, R2).
  task automatic frame(input int acc_h, input int ign_h, input bit vid, input bit coinc);
    int endh;
    int stop;
    vid_ok = vid;
    endh = vid ? 704 : 628;
    stop = (acc_h >= 0) ? acc_h : endh - 1;
    exp_q.push_back(stop);
    for (int h = 0; h <= stop; h++) begin
      if (h == stop) begin
        if (acc_h < 0)  cyc(1'b1, 1'b0);
        else if (coinc) cyc(1'b1, 1'b1);
        else            cyc(1'b0, 1'b1);
        cyc(1'b0, 1'b0);
      end else begin
        cyc(1'b0, h == ign_h);
        cyc(1'b0, 1'b0);
        cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b0);
      end
    end
  endtask

  // Monitor: pops expected frame starts and compares as the design produces them.
  initial begin
    int since = 0;
    int width = 0;
    bit vd_prev = 1'b0;
    bit tk;
    int e;
    wait (!rst);
    forever begin
      @(posedge clk);
      #5;
      if (done) break;
      tk = half_tick;
      if (vdrive && !vd_prev) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1/R2 unexpected frame start", since, -1);
        end else begin
          e = exp_q.pop_front();
          chk(since == e, "R1/R2/R4/R9 frame start position", since, e);
        end
        since = 0;
        width = 0;
        chk(line_cnt == 0, "R5 line count at start", line_cnt, 0);
        chk(pll_fast == 1'b1, "R6 fast at start", pll_fast, 1);
      end else begin
        if (tk) since++;
        if (vd_prev && tk) width++;
        if (vd_prev && !vdrive) chk(width == 21, "R3 vdrive width in ticks", width, 21);
        if (tk) begin
          chk(line_cnt == since / 2, "R5 line count", line_cnt, since / 2);
          chk(pll_fast == ((since < 20) || (since >= 619)), "R6 time constant select",
              pll_fast, (since < 20) || (since >= 619));
        end
      end
      if (pll_inhibit != vdrive) chk(1'b0, "R7 inhibit follows vdrive", pll_inhibit, vdrive);
      vd_prev = vdrive;
    end
  end

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #5;
        chk(line_cnt == 0, "R8 reset line_cnt", line_cnt, 0);
        chk(vdrive == 1'b0, "R8 reset vdrive", vdrive, 0);
        chk(pll_inhibit == 1'b0, "R8 reset inhibit", pll_inhibit, 0);
        chk(pll_fast == 1'b1, "R8 reset fast", pll_fast, 1);
        frame(560, -1, 1'b0, 1'b0);  // R1 mid window
        frame(496, -1, 1'b0, 1'b0);  // R1 lowest accepted position
        frame(-1, 495, 1'b0, 1'b0);  // R4 just early, R2 short window end
        frame(-1, -1, 1'b1, 1'b0);   // R2 long window end
        frame(650, -1, 1'b1, 1'b0);  // R2 beyond short window, identified
        frame(627, -1, 1'b0, 1'b1);  // R9 sync on the wrap tick
        frame(600, -1, 1'b1, 1'b1);  // R9 sync with tick mid window
        frame(625, 100, 1'b0, 1'b0); // R4 far early ignored, then accept
        repeat (40) cyc(1'b0, 1'b0);
        chk(exp_q.size() == 0, "R1/R2 all expected starts seen", exp_q.size(), 0);
      end
      begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule